// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block gives software control over a bank of general-purpose pins through a plain 32-bit register port. Each pin can be read back, switched between input and output, and driven high or low. Pins are driven by writing ones to separate set and clear words, so no read-modify-write of the output latch is needed. Each pin can also watch for rising edges, falling edges or both. A detected edge is held in a status bit until software writes a one to that bit. One interrupt line is the OR of all status bits.

Registers are grouped by feature. Each feature owns a run of consecutive 32-bit words, one word per 32 pins, so the stride between features grows with the pin count. A 2-bit alternate-function field is kept for each pin and driven out to the pad multiplexer. The field value 0 means plain GPIO. Pin inputs pass through a two-flop synchronizer before they are used for readback and edge detection.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, all pins are inputs (`pin_oe_o` is 0), the output latch is 0, every alternate-function field is 0, `irq_o` is low, and the direction and status words read 0.
- R2: With N = NUM_PINS/32, feature k occupies byte addresses k*N*4 + r*4. Here r is the word index and p/32 gives the word for pin p, at bit p%32. The feature order is: 0 level, 1 direction, 2 set, 3 clear, 4 rising enable, 5 falling enable, 6 edge status, 7 alternate function. Address bits [1:0] are ignored.
- R3: A 1 in a direction bit makes that pin an output (`pin_oe_o` high), and a 0 makes it an input. The direction word reads back as written.
- R4: Writing a 1 to a set-word bit drives that pin's output latch high. Writing a 1 to a clear-word bit drives it low. Zero bits leave the latch unchanged. The set and clear words read as 0.
- R5: The level words return the pin inputs after a two-flop synchronizer. Writes to level words change nothing.
- R6: When a pin's rising-enable bit is 1, a 0-to-1 change of its synchronized input sets its status bit. Without the enable, the change sets nothing.
- R7: When a pin's falling-enable bit is 1, a 1-to-0 change sets its status bit. The two enables are independent, and with both set either edge sets the status bit.
- R8: A status bit stays set until a 1 is written to it. Writing zero bits has no effect, and writing all ones clears every pending bit.
- R9: If an enabled edge and a write-one-to-clear hit the same status bit in the same cycle, the bit stays set.
- R10: `irq_o` is high exactly while at least one status bit is set.
- R11: The alternate-function field of pin p is 2 bits wide. It sits in alternate-function word p/16 at bit offset 2*(p%16), drives `alt_fn_o[2p+1:2p]`, and reads back as written.
- R12: A read of an address beyond the last alternate-function word returns 0, and a write to such an address changes no state.
- R13: Read data appears on `rdata_o` one clock after a read request (`req_i` high, `we_i` low) and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| pin_in_i | input | NUM_PINS | Pad input levels |
| pin_out_o | output | NUM_PINS | Output latch to pads |
| pin_oe_o | output | NUM_PINS | Output enable per pin |
| alt_fn_o | output | 2*NUM_PINS | Alternate-function select, 2 bits per pin |
| irq_o | output | 1 | Combined edge interrupt |

## Verification
Several properties are checked on every cycle. A status bit that is not being cleared never drops, and a new status bit needs an enable. A write-one to set or clear lands in the output latch, while writes to other features leave direction and the latch alone. Set and clear reads give zero, and the interrupt cannot rise with no edge enabled. Only the bench scenarios can show the address map, the synchronizer latency seen at the level word, and which edge polarity sets which bit. They also cover the alternate-function bit packing and the collision of an edge with a clear in the same cycle.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int WORD_W = 32;

  // order is the address map: feature k sits at k*N words
  typedef enum logic [2:0] {
    FEAT_LEVEL = 3'd0,
    FEAT_DIR   = 3'd1,
    FEAT_SET   = 3'd2,
    FEAT_CLR   = 3'd3,
    FEAT_RISE  = 3'd4,
    FEAT_FALL  = 3'd5,
    FEAT_STAT  = 3'd6,
    FEAT_ALTF  = 3'd7
  } gpio_feat_e;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_bank_pkg::*;
#(
  parameter int NW     = 2,
  parameter int ADDR_W = 7,
  parameter int IDX_W  = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output gpio_feat_e        feat_o,
  output logic [IDX_W-1:0]  word_o,
  output logic              hit_o
);
  localparam int ALTF_BASE = 7 * NW;
  localparam int MAP_END   = 9 * NW;

  logic [31:0] wi;

  always_comb begin
    wi     = 32'(addr_i[ADDR_W-1:2]);
    hit_o  = 1'b0;
    feat_o = FEAT_LEVEL;
    word_o = '0;
    if (wi < 32'(ALTF_BASE)) begin
      hit_o  = 1'b1;
      feat_o = gpio_feat_e'(3'(wi / 32'(NW)));
      word_o = IDX_W'(wi % 32'(NW));
    end else if (wi < 32'(MAP_END)) begin
      hit_o  = 1'b1;
      feat_o = FEAT_ALTF;
      word_o = IDX_W'(wi - 32'(ALTF_BASE));
    end
  end
endmodule

// File: rtl/gpio_edge_unit.sv
module gpio_edge_unit #(
  parameter int NUM_PINS = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] rise_en_i,
  input  logic [NUM_PINS-1:0] fall_en_i,
  input  logic [NUM_PINS-1:0] clr_i,
  output logic [NUM_PINS-1:0] level_o,
  output logic [NUM_PINS-1:0] status_o
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic s1_q, s2_q, prev_q, st_q;
    logic rise, fall;

    assign rise = s2_q & ~prev_q;
    assign fall = ~s2_q & prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        prev_q <= 1'b0;
        st_q   <= 1'b0;
      end else begin
        s1_q   <= pin_i[p];
        s2_q   <= s1_q;
        prev_q <= s2_q;
        // a fresh edge wins over a same-cycle clear
        st_q   <= (st_q & ~clr_i[p]) | (rise & rise_en_i[p]) | (fall & fall_en_i[p]);
      end
    end

    assign level_o[p]  = s2_q;
    assign status_o[p] = st_q;
  end

  // R8: a pending bit only drops when cleared
  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(status_o & ~clr_i) & ~status_o) == '0));

  // R6 / R7: a new status bit needs an edge enable
  p_need_enable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_o & ~$past(status_o) & ~$past(rise_en_i | fall_en_i)) == '0));
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 64,
  parameter int ADDR_W   = $clog2(9 * (NUM_PINS / 32) * 4)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [31:0]           wdata_i,
  output logic [31:0]           rdata_o,
  input  logic [NUM_PINS-1:0]   pin_in_i,
  output logic [NUM_PINS-1:0]   pin_out_o,
  output logic [NUM_PINS-1:0]   pin_oe_o,
  output logic [2*NUM_PINS-1:0] alt_fn_o,
  output logic                  irq_o
);
  localparam int NW    = NUM_PINS / WORD_W;
  localparam int NAW   = 2 * NW;
  localparam int IDX_W = $clog2(NAW);

  gpio_feat_e       feat;
  logic [IDX_W-1:0] word;
  logic             hit, wr_hit, rd_req;

  logic [NUM_PINS-1:0]   dir_q, dir_d, out_q, out_d, ren_q, ren_d, fen_q, fen_d;
  logic [NUM_PINS-1:0]   set_mask, clr_out_mask, stat_clr, level, status;
  logic [2*NUM_PINS-1:0] af_q, af_d;
  logic [31:0]           rd_d, rdata_q;

  gpio_addr_dec #(.NW(NW), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
    .addr_i (addr_i),
    .feat_o (feat),
    .word_o (word),
    .hit_o  (hit)
  );

  gpio_edge_unit #(.NUM_PINS(NUM_PINS)) u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pin_i     (pin_in_i),
    .rise_en_i (ren_q),
    .fall_en_i (fen_q),
    .clr_i     (stat_clr),
    .level_o   (level),
    .status_o  (status)
  );

  assign wr_hit = req_i & we_i & hit;
  assign rd_req = req_i & ~we_i;

  always_comb begin
    dir_d        = dir_q;
    ren_d        = ren_q;
    fen_d        = fen_q;
    af_d         = af_q;
    set_mask     = '0;
    clr_out_mask = '0;
    stat_clr     = '0;
    if (wr_hit) begin
      for (int w = 0; w < NW; w++) begin
        if (word == IDX_W'(w)) begin
          unique case (feat)
            FEAT_DIR:  dir_d[w*WORD_W +: WORD_W]        = wdata_i;
            FEAT_SET:  set_mask[w*WORD_W +: WORD_W]     = wdata_i;
            FEAT_CLR:  clr_out_mask[w*WORD_W +: WORD_W] = wdata_i;
            FEAT_RISE: ren_d[w*WORD_W +: WORD_W]        = wdata_i;
            FEAT_FALL: fen_d[w*WORD_W +: WORD_W]        = wdata_i;
            FEAT_STAT: stat_clr[w*WORD_W +: WORD_W]     = wdata_i;
            default: ;
          endcase
        end
      end
      if (feat == FEAT_ALTF) begin
        for (int w = 0; w < NAW; w++) begin
          if (word == IDX_W'(w)) af_d[w*WORD_W +: WORD_W] = wdata_i;
        end
      end
    end
    out_d = (out_q | set_mask) & ~clr_out_mask;
  end

  always_comb begin
    rd_d = '0;
    if (hit) begin
      for (int w = 0; w < NW; w++) begin
        if (word == IDX_W'(w)) begin
          unique case (feat)
            FEAT_LEVEL: rd_d = level[w*WORD_W +: WORD_W];
            FEAT_DIR:   rd_d = dir_q[w*WORD_W +: WORD_W];
            FEAT_RISE:  rd_d = ren_q[w*WORD_W +: WORD_W];
            FEAT_FALL:  rd_d = fen_q[w*WORD_W +: WORD_W];
            FEAT_STAT:  rd_d = status[w*WORD_W +: WORD_W];
            default: ;
          endcase
        end
      end
      if (feat == FEAT_ALTF) begin
        for (int w = 0; w < NAW; w++) begin
          if (word == IDX_W'(w)) rd_d = af_q[w*WORD_W +: WORD_W];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q   <= '0;
      out_q   <= '0;
      ren_q   <= '0;
      fen_q   <= '0;
      af_q    <= '0;
      rdata_q <= '0;
    end else begin
      dir_q <= dir_d;
      out_q <= out_d;
      ren_q <= ren_d;
      fen_q <= fen_d;
      af_q  <= af_d;
      if (rd_req) rdata_q <= rd_d;
    end
  end

  assign rdata_o   = rdata_q;
  assign pin_out_o = out_q;
  assign pin_oe_o  = dir_q;
  assign alt_fn_o  = af_q;
  assign irq_o     = |status;

  // R3: direction moves only on a direction write
  p_dir_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_hit && feat == FEAT_DIR) |=> $stable(dir_q));

  // R4: write-one set and clear land in the latch
  p_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((out_q & $past(set_mask)) == $past(set_mask)));
  p_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((out_q & $past(clr_out_mask)) == '0));

  // R4: set/clear words read as zero
  p_wo_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && hit && (feat == FEAT_SET || feat == FEAT_CLR)) |=> (rdata_o == '0));

  // R5: level writes touch nothing
  p_level_ro_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit && feat == FEAT_LEVEL) |=> ($stable(dir_q) && $stable(out_q) && $stable(af_q)));

  // R10: no interrupt can rise without an edge enable
  p_irq_src_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|(ren_q | fen_q)));
endmodule

// File: tb/sim_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_bank_ctrl;
  localparam int NP = 64;
  localparam int AW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic [2*NP-1:0] alt_fn;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  gpio_bank_ctrl #(.NUM_PINS(NP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_in_i(pin_in), .pin_out_o(pin_out),
    .pin_oe_o(pin_oe), .alt_fn_o(alt_fn), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    d = rdata;
    req = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 oe lo", pin_oe[31:0], 32'h0);
    chk("R1 oe hi", pin_oe[63:32], 32'h0);
    chk("R1 out", pin_out[31:0] | pin_out[63:32], 32'h0);
    chk("R1 altfn", alt_fn[31:0] | alt_fn[63:32] | alt_fn[95:64] | alt_fn[127:96], 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    rd(7'd8, v);  chk("R1 dir read", v, 32'h0);
    rd(7'd48, v); chk("R1 status read", v, 32'h0);
  endtask

  task automatic t_dir();
    logic [31:0] v;
    wr(7'd8, 32'h0000_00F0);
    wr(7'd12, 32'h8000_0001);
    chk("R3 oe word0", pin_oe[31:0], 32'h0000_00F0);
    chk("R2 oe word1", pin_oe[63:32], 32'h8000_0001);
    rd(7'd12, v); chk("R3 dir readback", v, 32'h8000_0001);
    rd(7'd13, v); chk("R2 low addr bits ignored", v, 32'h8000_0001);
  endtask

  task automatic t_setclr();
    logic [31:0] v;
    wr(7'd16, 32'h0000_000F);
    wr(7'd20, 32'h0000_0001);
    chk("R4 set word0", pin_out[31:0], 32'h0000_000F);
    chk("R4 set word1", pin_out[63:32], 32'h0000_0001);
    wr(7'd24, 32'h0000_0005);
    chk("R4 clear", pin_out[31:0], 32'h0000_000A);
    wr(7'd24, 32'h0);
    wr(7'd16, 32'h0);
    chk("R4 zero bits no effect", pin_out[31:0], 32'h0000_000A);
    rd(7'd16, v); chk("R4 set reads 0", v, 32'h0);
    rd(7'd28, v); chk("R4 clear reads 0", v, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    @(negedge clk);
    pin_in = {32'hDEAD_BEEF, 32'h1234_5678};
    repeat (3) @(negedge clk);
    rd(7'd0, v); chk("R5 level word0", v, 32'h1234_5678);
    rd(7'd4, v); chk("R5 level word1", v, 32'hDEAD_BEEF);
    wr(7'd0, 32'h0);
    rd(7'd0, v); chk("R5 level write ignored", v, 32'h1234_5678);
    chk("R5 latch untouched", pin_out[31:0], 32'h0000_000A);
    @(negedge clk);
    pin_in = '0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_edges();
    logic [31:0] v;
    wr(7'd32, 32'h5);
    wr(7'd40, 32'h6);
    @(negedge clk);
    pin_in[2:0] = 3'b111;
    repeat (4) @(negedge clk);
    rd(7'd48, v); chk("R6 rising sets only enabled bits", v, 32'h5);
    chk("R10 irq high", {31'h0, irq}, 32'h1);
    @(negedge clk);
    pin_in[2:0] = 3'b000;
    repeat (4) @(negedge clk);
    rd(7'd48, v); chk("R7 falling and both-edge", v, 32'h7);
    wr(7'd48, 32'h1);
    rd(7'd48, v); chk("R8 w1c single bit", v, 32'h6);
    rd(7'd48, v); chk("R8 sticky", v, 32'h6);
    wr(7'd48, 32'hFFFF_FFFF);
    rd(7'd48, v); chk("R8 all ones clears", v, 32'h0);
    chk("R10 irq low", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_coincide();
    logic [31:0] v;
    wr(7'd32, 32'h1);
    wr(7'd40, 32'h0);
    @(negedge clk);
    pin_in[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 7'd48; wdata = 32'h1;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    rd(7'd48, v); chk("R9 edge beats clear", v, 32'h1);
    chk("R10 irq after collision", {31'h0, irq}, 32'h1);
    wr(7'd48, 32'h1);
    rd(7'd48, v); chk("R9 later clear works", v, 32'h0);
  endtask

  task automatic t_altfn();
    logic [31:0] v;
    wr(7'd56, 32'h0000_000C);
    wr(7'd68, 32'h8000_0000);
    chk("R11 pin1 field", {30'h0, alt_fn[3:2]}, 32'h3);
    chk("R11 pin0 field", {30'h0, alt_fn[1:0]}, 32'h0);
    chk("R11 pin63 field", {30'h0, alt_fn[127:126]}, 32'h2);
    rd(7'd68, v); chk("R11 readback", v, 32'h8000_0000);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(7'd72, 32'hFFFF_FFFF);
    wr(7'd124, 32'hFFFF_FFFF);
    rd(7'd72, v); chk("R12 unmapped reads 0", v, 32'h0);
    rd(7'd8, v);  chk("R12 dir untouched", v, 32'h0000_00F0);
    chk("R12 latch untouched", pin_out[31:0], 32'h0000_000A);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 7'd12;
    @(negedge clk);
    req = 1'b0; addr = 7'd8;
    chk("R13 data one clock after request", rdata, 32'h8000_0001);
    @(negedge clk);
    chk("R13 data holds", rdata, 32'h8000_0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_dir();
    t_setclr();
    t_level();
    t_edges();
    t_coincide();
    t_altfn();
    t_unmapped();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule